// File: doc/BRIEF.md
# Prescaled Modulus Timer Counter

This block is the shared 16-bit time base for a group of capture/compare channels. Each cycle it takes a count tick from one of three sources: every cycle of the bus clock, a strobe from a fixed system clock, or the rising edge of an external pin that has been synchronised through two flops. A source setting of "off" halts the timer. The ticks then pass through a power-of-two prescaler before they advance the counter.

The counter runs in one of two shapes. In edge-aligned mode it climbs from zero to a terminal value and then wraps to zero. In center-aligned mode it climbs to the terminal value, then falls back to zero, and repeats, which suits symmetric PWM. The terminal value comes from a modulus input. A modulus of zero selects the full 16-bit range. Each completed period sets a sticky overflow flag, and a software strobe clears it. A registered interrupt request follows the flag while interrupts are enabled. The channels read the count value and the current direction.

Top module: `pmt_timebase`

## Requirements
- R1: While reset is high and on the first cycle after it, count is 0, count_down is 0, ovf_flag is 0 and irq is 0.
- R2: clk_sel chooses the tick source: 0 = off (count frozen), 1 = every clk cycle, 2 = each cycle with fixed_tick high, 3 = each rising edge of ext_pin. A change on ext_pin reaches the counter on the second clk edge after the pin is sampled.
- R3: With presc_sel = n (0..7), the counter advances once per 2^n source ticks. The first advance after reset comes on the 2^n-th tick.
- R4: With center_mode low, the count goes 0,1,...,T and then 0, where T = modulus, or 0xFFFF when modulus is 0. If a step finds the count at or above T, the count wraps to 0.
- R5: With center_mode high, the count rises to T, then falls to 0, then rises again. The step taken at T produces T-1 and sets count_down. The step taken at 0 while falling produces 1 and clears count_down.
- R6: ovf_flag is set by the wrap step in edge-aligned mode and by the turn at T in center-aligned mode. It then stays set.
- R7: A one-cycle pulse on ovf_clr clears ovf_flag on the next clk edge, unless a new terminal event occurs in that same cycle. In that case the flag stays set.
- R8: irq is a registered copy of (next ovf_flag AND irq_en), so it rises together with ovf_flag when irq_en is high.
- R9: A change of clk_sel or presc_sel restarts the prescaler phase at zero. No step is taken in the cycle in which the change is seen.
- R10: An ext_pin that is held high gives exactly one tick, no matter how long it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Tick source: 0 off, 1 bus, 2 fixed strobe, 3 external pin |
| fixed_tick | input | 1 | One-cycle strobe from the fixed system clock |
| ext_pin | input | 1 | Asynchronous external clock pin |
| presc_sel | input | 3 | Prescaler exponent, divide by 2^presc_sel |
| center_mode | input | 1 | 1 = up/down counting, 0 = up-count with wrap |
| modulus | input | 16 | Terminal count, 0 means 0xFFFF |
| irq_en | input | 1 | Interrupt enable |
| ovf_clr | input | 1 | Write-one strobe that clears the overflow flag |
| count | output | 16 | Current counter value |
| count_down | output | 1 | High while counting downward |
| ovf_flag | output | 1 | Sticky terminal-count flag |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that center_mode and clk_sel hold still across any pair of cycles they compare. They also assume that modulus only moves while the timer is stopped or in edge-aligned mode, so any count change outside a wrap is a single increment. The stimulus keeps to this: every mode, source and modulus is applied under reset or while the source is off. The one exception is a deliberate lowering of modulus in edge-aligned mode, which is exactly the wrap case the properties allow. The external pin is driven with pulses at least two cycles wide, so the two-flop synchroniser never has to catch a shorter event.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_BUS   = 2'd1,
    SRC_FIXED = 2'd2,
    SRC_EXT   = 2'd3
  } src_e;

  localparam int CNT_W   = 16;
  localparam int PS_W    = 3;
  localparam int SYNC_N  = 2;
endpackage

// File: rtl/pmt_edge_sync.sv
module pmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src_tick,
  input  logic            restart,
  input  logic [PS_W-1:0] ps_sel,
  output logic            step
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) begin
      mask[i] = (i < int'(ps_sel));
    end
  end

  assign step = src_tick & ~restart & ((phase_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart)  phase_q <= '0;
    else if (src_tick)   phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/pmt_updown.sv
module pmt_updown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         center,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] count,
  output logic         down,
  output logic         term
);
  logic [W-1:0] top;
  logic [W-1:0] cnt_d;
  logic         down_d;

  assign top = (modulus == '0) ? {W{1'b1}} : modulus;

  always_comb begin
    cnt_d  = count;
    down_d = center ? down : 1'b0;
    term   = 1'b0;
    if (step) begin
      if (!center) begin
        if (count >= top) begin
          cnt_d = '0;
          term  = 1'b1;
        end else begin
          cnt_d = count + 1'b1;
        end
      end else if (!down) begin
        if (count >= top) begin
          cnt_d  = count - 1'b1;
          down_d = 1'b1;
          term   = 1'b1;
        end else begin
          cnt_d = count + 1'b1;
        end
      end else begin
        if (count == '0) begin
          cnt_d  = {{(W-1){1'b0}}, 1'b1};
          down_d = 1'b0;
        end else begin
          cnt_d = count - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      down  <= 1'b0;
    end else begin
      count <= cnt_d;
      down  <= down_d;
    end
  end
endmodule

// File: rtl/pmt_timebase.sv
module pmt_timebase
  import pmt_pkg::*;
#(
  parameter int W      = CNT_W,
  parameter int PSW    = PS_W,
  parameter int STAGES = SYNC_N
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     clk_sel,
  input  logic           fixed_tick,
  input  logic           ext_pin,
  input  logic [PSW-1:0] presc_sel,
  input  logic           center_mode,
  input  logic [W-1:0]   modulus,
  input  logic           irq_en,
  input  logic           ovf_clr,
  output logic [W-1:0]   count,
  output logic           count_down,
  output logic           ovf_flag,
  output logic           irq
);
  logic           ext_rise;
  logic           src_tick;
  logic           restart;
  logic           step;
  logic           term;
  logic           flag_d;
  logic [1:0]     sel_q;
  logic [PSW-1:0] ps_q;

  pmt_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_pin),
    .rise (ext_rise)
  );

  always_comb begin
    unique case (src_e'(clk_sel))
      SRC_BUS:   src_tick = 1'b1;
      SRC_FIXED: src_tick = fixed_tick;
      SRC_EXT:   src_tick = ext_rise;
      default:   src_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    sel_q <= clk_sel;
    ps_q  <= presc_sel;
  end

  assign restart = ~rst & ((clk_sel != sel_q) | (presc_sel != ps_q));

  pmt_prescaler #(.PS_W(PSW)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .src_tick (src_tick),
    .restart  (restart),
    .ps_sel   (presc_sel),
    .step     (step)
  );

  pmt_updown #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .center  (center_mode),
    .modulus (modulus),
    .count   (count),
    .down    (count_down),
    .term    (term)
  );

  assign flag_d = term | (ovf_flag & ~ovf_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ovf_flag <= flag_d;
      irq      <= flag_d & irq_en;
    end
  end
endmodule

// File: rtl/pmt_timebase_chk.sv
module pmt_timebase_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   clk_sel,
  input logic         center_mode,
  input logic [W-1:0] count,
  input logic         count_down,
  input logic         ovf_flag,
  input logic         irq
);
  // R4: in edge-aligned mode the count only increments or wraps to zero
  p_up_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !center_mode && !$past(center_mode) && count != $past(count))
      |-> (count == $past(count) + 1'b1 || count == '0));

  // R6: a wrap to zero in edge-aligned mode leaves the flag set
  p_wrap_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !center_mode && !$past(center_mode) && $past(count) != '0 && count == '0)
      |-> ovf_flag);

  // R5: turning downward at the top marks the period
  p_turn_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(count_down)) |-> ovf_flag);

  // R2: with no source selected the count is frozen
  p_off_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && clk_sel == 2'd0 && $past(clk_sel) == 2'd0) |-> $stable(count));

  // R8: an interrupt request is never raised without the flag
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovf_flag);

  // R5: descending only happens in center-aligned mode
  p_down_mode_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && count_down) |-> $past(center_mode));
endmodule

bind pmt_timebase pmt_timebase_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clk_sel     (clk_sel),
  .center_mode (center_mode),
  .count       (count),
  .count_down  (count_down),
  .ovf_flag    (ovf_flag),
  .irq         (irq)
);

// File: tb/pmt_timebase_test.sv
module pmt_timebase_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  clk_sel = 2'd1;
  logic        fixed_tick = 1'b0;
  logic        ext_pin = 1'b0;
  logic [2:0]  presc_sel = 3'd0;
  logic        center_mode = 1'b0;
  logic [15:0] modulus = 16'd0;
  logic        irq_en = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [15:0] count;
  logic        count_down;
  logic        ovf_flag;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmt_timebase uut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .fixed_tick(fixed_tick),
    .ext_pin(ext_pin), .presc_sel(presc_sel), .center_mode(center_mode),
    .modulus(modulus), .irq_en(irq_en), .ovf_clr(ovf_clr),
    .count(count), .count_down(count_down), .ovf_flag(ovf_flag), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  src;
    logic [2:0]  ps;
    logic        ctr;
    logic [15:0] md;
    logic [15:0] cyc;
    logic [15:0] cnt;
    logic        dn;
    logic        fl;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 3'd0, 1'b0, 16'd9,   16'd5,    16'd5,    1'b0, 1'b0},
    '{2'd1, 3'd0, 1'b0, 16'd9,   16'd10,   16'd0,    1'b0, 1'b1},
    '{2'd1, 3'd0, 1'b0, 16'd9,   16'd13,   16'd3,    1'b0, 1'b1},
    '{2'd1, 3'd3, 1'b0, 16'd100, 16'd40,   16'd5,    1'b0, 1'b0},
    '{2'd1, 3'd7, 1'b0, 16'd0,   16'd300,  16'd2,    1'b0, 1'b0},
    '{2'd1, 3'd0, 1'b0, 16'd0,   16'd1000, 16'd1000, 1'b0, 1'b0},
    '{2'd1, 3'd0, 1'b1, 16'd4,   16'd3,    16'd3,    1'b0, 1'b0},
    '{2'd1, 3'd0, 1'b1, 16'd4,   16'd4,    16'd4,    1'b0, 1'b0},
    '{2'd1, 3'd0, 1'b1, 16'd4,   16'd5,    16'd3,    1'b1, 1'b1},
    '{2'd1, 3'd0, 1'b1, 16'd4,   16'd8,    16'd0,    1'b1, 1'b1},
    '{2'd1, 3'd0, 1'b1, 16'd4,   16'd9,    16'd1,    1'b0, 1'b1},
    '{2'd1, 3'd1, 1'b1, 16'd4,   16'd10,   16'd3,    1'b1, 1'b1},
    '{2'd0, 3'd0, 1'b0, 16'd9,   16'd50,   16'd0,    1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart_with(input logic [1:0] s, input logic [2:0] p,
                              input logic c, input logic [15:0] m);
    @(negedge clk);
    rst = 1'b1;
    clk_sel = s;
    presc_sel = p;
    center_mode = c;
    modulus = m;
    fixed_tick = 1'b0;
    ext_pin = 1'b0;
    ovf_clr = 1'b0;
    irq_en = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  initial begin
    // R1: reset state
    restart_with(2'd1, 3'd0, 1'b0, 16'd9);
    check("R1 count", count, 0);
    check("R1 dir", count_down, 0);
    check("R1 flag", ovf_flag, 0);
    check("R1 irq", irq, 0);

    // Table-driven cases for R2 (bus/off), R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      restart_with(VEC[i].src, VEC[i].ps, VEC[i].ctr, VEC[i].md);
      step(int'(VEC[i].cyc));
      check($sformatf("R3/R4/R5 count vec%0d", i), count, VEC[i].cnt);
      check($sformatf("R5 dir vec%0d", i), count_down, VEC[i].dn);
      check($sformatf("R6 flag vec%0d", i), ovf_flag, VEC[i].fl);
    end

    // R4: full 16-bit range when modulus is zero
    restart_with(2'd1, 3'd0, 1'b0, 16'd0);
    step(65535);
    check("R4 full range top", count, 16'hFFFF);
    check("R6 no flag before wrap", ovf_flag, 0);
    step(1);
    check("R4 full range wrap", count, 0);
    check("R6 flag on wrap", ovf_flag, 1);

    // R2: fixed-clock strobe source
    restart_with(2'd2, 3'd0, 1'b0, 16'd0);
    for (int k = 0; k < 7; k++) begin
      fixed_tick = 1'b1;
      step(1);
      fixed_tick = 1'b0;
      step(2);
    end
    check("R2 fixed strobe count", count, 7);

    // R2 and R10: external pin through synchroniser
    restart_with(2'd3, 3'd0, 1'b0, 16'd0);
    for (int k = 0; k < 5; k++) begin
      ext_pin = 1'b1;
      step(2);
      ext_pin = 1'b0;
      step(2);
    end
    check("R2 ext pin count", count, 5);
    ext_pin = 1'b1;
    step(10);
    check("R10 held pin single tick", count, 6);

    // R9: prescaler phase restarts on a change
    restart_with(2'd1, 3'd2, 1'b0, 16'd0);
    step(3);
    check("R3 before divide step", count, 0);
    presc_sel = 3'd1;
    step(2);
    check("R9 phase restarted", count, 0);
    step(1);
    check("R9 first step after change", count, 1);

    // R4: lowering modulus below the count forces a wrap
    restart_with(2'd1, 3'd0, 1'b0, 16'd0);
    step(20);
    check("R4 count before lowering", count, 20);
    modulus = 16'd9;
    step(1);
    check("R4 wrap when above top", count, 0);
    check("R6 flag on forced wrap", ovf_flag, 1);

    // R8 / R7: interrupt gating and flag clear
    check("R8 irq masked", irq, 0);
    irq_en = 1'b1;
    step(1);
    check("R8 irq follows flag", irq, 1);
    clk_sel = 2'd0;
    ovf_clr = 1'b1;
    step(1);
    ovf_clr = 1'b0;
    check("R7 flag cleared", ovf_flag, 0);
    check("R8 irq drops with flag", irq, 0);
    step(3);
    check("R7 flag stays clear", ovf_flag, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule